// File: doc/BRIEF.md
# Synchronous Pipelined Flash Read Interface

This block is the device-side read path of a two-bank flash memory. It has a clocked, pipelined read interface. A read starts when the address-valid strobe is low at a rising clock edge while the device is selected and no write is in progress. Address bit 1 picks the even or odd bank. The formatted data reaches the output register a programmable number of clock edges later. It stays there until the chip is deselected, output enable goes high, or a later access completes. This lets the host overlap the next address phase with the current data phase.

The array is a behavioural register array in two banks. Reset loads it with a fixed, computed pattern. A dedicated load port sets the latency. Two active-low chip enables, an output enable, a write-enable input and a byte/word mode input control when and how the data bus drives. The low reset/power-down input aborts any access and returns the block to read-array mode.

Top module: `sync_flash_rd`

## Requirements
- R1: While `rst_n` is low, and after it rises, both output-enable flags are 0, no access is in flight, and the latency is 4.
- R2: An access is accepted at a rising edge where `adv_n`=0, `ce0_n`=0, `ce1_n`=0 and `we_n`=1. `addr[1]` selects the bank (0 even, 1 odd) and `addr[ADDR_W-1:2]` selects the row. The word read is ((2*row+bank)*16'h0101) XOR 16'hA53C.
- R3: The output register takes the data of an access accepted at edge N at edge N+L, where L is the latency in force at edge N.
- R4: A load on `cfg_load` sets the latency to `cfg_val` when the value is 2 to 7. A value of 0 or 1 sets it to 4. The new value applies to accesses accepted after the load edge.
- R5: A new access accepted while another is counting replaces it. The previous output data stays driven until the new access completes.
- R6: `dq_oe_lo` is 1 only when valid data is held, both chip enables are low and `oe_n` is low. At an edge with a chip enable or `oe_n` high and no completion, the held data is invalidated.
- R7: With `byte_n`=0 the access returns {8'h00, byte}, where the byte is word[15:8] if `addr[0]`=1 and word[7:0] otherwise. `dq_oe_hi` is then 0. With `byte_n`=1 the full word is returned and `addr[0]` has no effect.
- R8: While `we_n` is low, `adv_n` is ignored and the latency count of an in-flight access is frozen. Counting resumes when `we_n` returns high.
- R9: Output enable wins over write enable: held data keeps driving with `oe_n` low even while `we_n` is low.
- R10: Pulling `rst_n` low aborts an in-flight access. That access never reaches the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read interface clock |
| rst_n | input | 1 | Asynchronous active-low reset / power-down |
| adv_n | input | 1 | Active-low address-valid strobe |
| ce0_n | input | 1 | Active-low chip enable 0 |
| ce1_n | input | 1 | Active-low chip enable 1 |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable (low = write in progress) |
| byte_n | input | 1 | 0 = 8-bit mode, 1 = 16-bit mode |
| addr | input | ADDR_W | Byte address: bit 0 byte lane, bit 1 bank, upper bits row |
| cfg_load | input | 1 | Latency load strobe |
| cfg_val | input | LAT_W | Latency value to load |
| dq_out | output | 16 | Read data, zero when not driving |
| dq_oe_lo | output | 1 | Drive enable for the low data byte |
| dq_oe_hi | output | 1 | Drive enable for the high data byte |

## Verification
The hardest case to reach is a completion that lands on the same edge as something else: a new strobe, a frozen write phase, or a deselect. Every such collision changes which data is held and for how long. The stimulus issues strobes on consecutive cycles and at spacings shorter than the latency. It also drops `we_n` in the middle of a count and toggles the enables around completion edges. A behavioural model tracks each access by its due cycle number and compares the bus and both enables on every clock.

// File: rtl/sync_flash_rd.sv
module sync_flash_rd #(
  parameter int          ADDR_W  = 8,
  parameter int          LAT_W   = 3,
  parameter int          LAT_DEF = 4,
  parameter int          LAT_MIN = 2,
  parameter logic [15:0] MIX     = 16'hA53C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_n,
  input  logic              ce0_n,
  input  logic              ce1_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              byte_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_load,
  input  logic [LAT_W-1:0]  cfg_val,
  output logic [15:0]       dq_out,
  output logic              dq_oe_lo,
  output logic              dq_oe_hi
);
  localparam int ROW_W = ADDR_W - 2;
  localparam int ROWS  = 1 << ROW_W;

  logic [ROW_W-1:0]  row;
  logic [1:0][15:0]  word_at;
  logic [15:0]       word_sel, fmt;
  logic              sel, take, done;
  logic              pend, out_valid;
  logic [LAT_W-1:0]  cnt, lat;
  logic [15:0]       pdata, out_q;

  assign row = addr[ADDR_W-1:2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [15:0] bank_q [ROWS];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        for (int r = 0; r < ROWS; r++) bank_q[r] <= 16'((r * 2 + b) * 257) ^ MIX;
    assign word_at[b] = bank_q[row];
  end

  assign word_sel = word_at[addr[1]];
  assign fmt  = byte_n ? word_sel : {8'h00, addr[0] ? word_sel[15:8] : word_sel[7:0]};
  assign sel  = ~ce0_n & ~ce1_n;
  assign take = sel & ~adv_n & we_n;
  assign done = we_n & pend & (cnt == LAT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat       <= LAT_W'(LAT_DEF);
      pend      <= 1'b0;
      cnt       <= '0;
      pdata     <= '0;
      out_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (cfg_load) lat <= (cfg_val < LAT_W'(LAT_MIN)) ? LAT_W'(LAT_DEF) : cfg_val;
      if (we_n) begin
        if (done) out_q <= pdata;
        if (take) begin
          pend  <= 1'b1;
          cnt   <= lat;
          pdata <= fmt;
        end else if (done) pend <= 1'b0;
        else if (pend)     cnt  <= cnt - 1'b1;
      end
      if (done)               out_valid <= 1'b1;
      else if (!sel || oe_n)  out_valid <= 1'b0;
    end
  end

  assign dq_oe_lo = out_valid & sel & ~oe_n;
  assign dq_oe_hi = dq_oe_lo & byte_n;
  assign dq_out   = dq_oe_lo ? out_q : '0;

  // R4
  lat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat >= LAT_W'(LAT_MIN));
  // R4
  cfg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && (cfg_val < LAT_W'(LAT_MIN)) |=> lat == LAT_W'(LAT_DEF));
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pend && (cnt == $past(lat)));
  // R8
  wr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n && pend |=> pend && $stable(cnt));
  // R6
  desel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || oe_n) && !done |=> !out_valid);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !done && sel && !oe_n |=> out_valid && $stable(out_q));
endmodule

// File: tb/sync_flash_rd_tb_top.sv
module sync_flash_rd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n, adv_n, ce0_n, ce1_n, oe_n, we_n, byte_n, cfg_load;
  logic [ADDR_W-1:0] addr;
  logic [2:0] cfg_val;
  logic [15:0] dq_out;
  logic dq_oe_lo, dq_oe_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_flash_rd #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .ce0_n(ce0_n), .ce1_n(ce1_n),
    .oe_n(oe_n), .we_n(we_n), .byte_n(byte_n), .addr(addr),
    .cfg_load(cfg_load), .cfg_val(cfg_val),
    .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi));

  int n_run = 0, n_fail = 0, wd = 0;
  bit finished = 0;
  string req_tag = "R1";

  int cyc = 0, m_lat = 4, m_due = 0;
  bit m_pend = 0, m_valid = 0;
  logic [15:0] m_pdata = '0, m_data = '0;

  function automatic logic [15:0] mem_word(logic [ADDR_W-1:0] a);
    int idx;
    idx = int'(a[ADDR_W-1:2]) * 2 + int'(a[1]);
    return 16'(idx * 257) ^ 16'hA53C;
  endfunction

  function automatic logic [15:0] shaped(logic [ADDR_W-1:0] a, logic bm);
    logic [15:0] w;
    w = mem_word(a);
    if (bm) return w;
    return {8'h00, a[0] ? w[15:8] : w[7:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = 4; m_pend = 0; m_valid = 0; m_data = '0;
    end else begin
      bit fin, on;
      cyc++;
      fin = 0;
      on = !ce0_n && !ce1_n;
      if (we_n) begin
        if (m_pend && cyc == m_due) begin
          fin = 1; m_valid = 1; m_data = m_pdata; m_pend = 0;
        end
        if (on && !adv_n) begin
          m_pend = 1; m_due = cyc + m_lat; m_pdata = shaped(addr, byte_n);
        end
      end else if (m_pend) m_due++;
      if (!fin && (!on || oe_n)) m_valid = 0;
      if (cfg_load) m_lat = (cfg_val < 3'd2) ? 4 : int'(cfg_val);
    end
  end

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic e_lo, e_hi;
    e_lo = m_valid && !ce0_n && !ce1_n && !oe_n && rst_n;
    e_hi = e_lo && byte_n;
    chk("dq_oe_lo", 16'(dq_oe_lo), 16'(e_lo));
    chk("dq_oe_hi", 16'(dq_oe_hi), 16'(e_hi));
    if (e_lo) chk("dq_out", e_hi ? dq_out : {8'h00, dq_out[7:0]},
                  e_hi ? m_data : {8'h00, m_data[7:0]});
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL %s watchdog: got %0d expected %0d", req_tag, wd, 20000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic rd(logic [ADDR_W-1:0] a);
    adv_n = 0; addr = a; step(1); adv_n = 1;
  endtask

  task automatic cfg(logic [2:0] v);
    cfg_load = 1; cfg_val = v; step(1); cfg_load = 0;
  endtask

  initial begin
    rst_n = 0; adv_n = 1; ce0_n = 0; ce1_n = 0; oe_n = 0; we_n = 1;
    byte_n = 1; cfg_load = 0; cfg_val = '0; addr = '0;
    step(3);
    rst_n = 1;
    req_tag = "R1"; rd(8'h10); step(6);
    req_tag = "R2";
    rd(8'h00); step(5); rd(8'h02); step(5); rd(8'h06); step(5);
    rd(8'hFE); step(5); rd(8'h7A); step(5);
    req_tag = "R3"; cfg(3); rd(8'h44); step(1); rd(8'h46); step(5);
    req_tag = "R4";
    cfg(2); rd(8'h20); step(4);
    cfg(7); rd(8'h22); step(9);
    cfg(0); rd(8'h24); step(6);
    cfg(1); rd(8'h26); step(6);
    cfg(5); rd(8'h28); step(7);
    cfg(4);
    req_tag = "R5";
    for (int i = 0; i < 6; i++) rd(ADDR_W'(8'h30 + 2 * i));
    step(6);
    rd(8'h50); step(5); rd(8'h52); step(2); rd(8'h54); step(6);
    req_tag = "R6";
    rd(8'h60); step(5);
    ce1_n = 1; step(2); ce1_n = 0; step(2);
    rd(8'h62); step(5);
    oe_n = 1; step(2); oe_n = 0; step(2);
    rd(8'h64); step(2); oe_n = 1; step(3); oe_n = 0; step(2);
    ce0_n = 1; rd(8'h66); step(6); ce0_n = 0; step(2);
    req_tag = "R7";
    byte_n = 0;
    rd(8'h11); step(5); rd(8'h10); step(5); rd(8'h13); step(5);
    byte_n = 1;
    rd(8'h11); step(5); rd(8'h10); step(5);
    req_tag = "R8";
    rd(8'h70); step(5);
    we_n = 0; adv_n = 0; addr = 8'h72; step(3); adv_n = 1; we_n = 1; step(6);
    rd(8'h74); step(2); we_n = 0; step(3); we_n = 1; step(5);
    req_tag = "R9";
    rd(8'h76); step(5); we_n = 0; step(3); we_n = 1; step(2);
    req_tag = "R10";
    cfg(7); rd(8'h78); step(3); rst_n = 0; step(2); rst_n = 1; step(9);
    rd(8'h7C); step(6);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule